// File: doc/BRIEF.md
# Frequency Offset Slew Limiter

This block produces the signed fractional-frequency offset word that steers a clock synthesizer. From the operating mode, a holdover-source choice and the live offset inputs (tracked reference offset, accumulated holdover history, short-term history) it forms a target offset. The target always sits on top of a programmed freerun calibration offset. It then walks its output toward that target on a 1 ms tick, no faster than a selected slew rate, so that mode changes and reference switches never produce a frequency step larger than the rate allows.

Software programs four registers through a simple write port and can read them back, together with the live short-term history value, through a read port. The history read lets software build its own holdover value. In tracking mode, a reference offset beyond the programmed pull-in limit is either clamped at that limit or followed anyway, as a control bit selects. The output is one offset word in units of 0.001 ppm, plus a flag that shows whether the output is still moving.

Top module: `offset_slew_limiter`

## Requirements
- R1: While reset is high and on the first cycle after it, the output word is 0, ramping is 0, and every register reads back as 0.
- R2: The calibration register (address 1, bits [10:0]) holds an 11-bit two's-complement code of 0.1 ppm per step. In mode 0 (freerun), and in the unused mode 3, the target is that code times 100 output units of 0.001 ppm.
- R3: The control register (address 0) has mode in bits [1:0] and the holdover source in bit 2. In mode 1 (holdover), the target is the calibration term plus the history input when bit 2 is 0. When bit 2 is 1, the target is the calibration term plus the user offset register (address 2, signed, full width).
- R4: In mode 2 (tracking) with the reference present, the target is the calibration term plus the reference offset. When control bit 3 is 0, that offset is first clamped to plus or minus the pull-in limit (address 3, bits [OFS_W-2:0], unsigned). When bit 3 is 1, it is passed through unclamped.
- R5: In mode 2 with the reference-lost input high, the target is the calibration term plus the short-term history input.
- R6: The output changes only on a clock edge where tick is high. With rate code 0 (control bits [5:4]) it moves by 1 unit per tick. With rate code 2 it moves by 2 units per tick.
- R7: With rate code 1 the steps alternate 1, 2, 1, 2 units. A step of 1 comes first after any tick at which the rate code was not 1 or the output already equalled the target.
- R8: With rate code 3, the output equals the target after the next tick.
- R9: The output never passes the target. A final step shorter than the rate lands exactly on the target.
- R10: The ramping output is high exactly when the output word differs from the current target, with no register delay.
- R11: Read addresses 0 to 3 return the control register (zero-extended), the calibration register (sign-extended), the user offset and the pull-in limit (zero-extended). Address 4 returns the short-term history input, and addresses 5 to 7 return 0.
- R12: The target saturates to the most positive or most negative value of the OFS_W-bit output word instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe every 1 ms that advances the ramp |
| cfg_wr | input | 1 | Register write enable |
| cfg_waddr | input | 3 | Register write address |
| cfg_wdata | input | OFS_W | Register write data |
| cfg_raddr | input | 3 | Register read address |
| cfg_rdata | output | OFS_W | Register read data (combinational) |
| ref_ofs | input | OFS_W | Tracked reference offset, signed, 0.001 ppm units |
| ref_lost | input | 1 | Reference signal lost |
| hist_ofs | input | OFS_W | Accumulated holdover history, signed |
| st_hist | input | OFS_W | Short-term history, signed |
| ofs_out | output | OFS_W | Slewed offset word, signed, 0.001 ppm units |
| ramping | output | 1 | Output differs from target |

## Verification
The hardest condition to reach is the 1.5-rate phase. Its alternation depends on the history of earlier ticks, on whether the target was reached and on rate changes made between ticks, so it shows up only during long ramps with odd remainders. The stimulus runs ramps of several hundred ticks with odd distances at each rate, and changes the target and the rate while a ramp is under way. Saturation is reached by putting the calibration code at either extreme together with a near-full-scale reference offset that is allowed to pass the pull-in limit. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/osl_pkg.sv
package osl_pkg;

    localparam int CAL_W     = 11;
    localparam int CAL_SCALE = 100;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_USER = 3'd2;
    localparam logic [ADDR_W-1:0] A_LIM  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STH  = 3'd4;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_TRK  = 2'd2,
        MODE_RSV  = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        RATE_1    = 2'd0,
        RATE_1P5  = 2'd1,
        RATE_2    = 2'd2,
        RATE_NONE = 2'd3
    } slew_rate_e;

    typedef struct packed {
        slew_rate_e rate;
        logic       follow;
        logic       ho_user;
        op_mode_e   mode;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [1:0] step_size(slew_rate_e r, logic ph);
        case (r)
            RATE_1:   step_size = 2'd1;
            RATE_1P5: step_size = ph ? 2'd2 : 2'd1;
            RATE_2:   step_size = 2'd2;
            default:  step_size = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/osl_regs.sv
module osl_regs
    import osl_pkg::*;
#(
    parameter int OFS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [OFS_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic signed [OFS_W-1:0] st_hist,
    output logic [OFS_W-1:0]        rd_data,
    output ctl_t                    ctl,
    output logic signed [CAL_W-1:0] cal,
    output logic signed [OFS_W-1:0] user_ofs,
    output logic [OFS_W-2:0]        pull_lim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            cal      <= '0;
            user_ofs <= '0;
            pull_lim <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTL:   ctl      <= ctl_t'(wr_data[CTL_W-1:0]);
                A_CAL:   cal      <= wr_data[CAL_W-1:0];
                A_USER:  user_ofs <= wr_data;
                A_LIM:   pull_lim <= wr_data[OFS_W-2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTL:   rd_data = OFS_W'(ctl);
            A_CAL:   rd_data = OFS_W'(cal);
            A_USER:  rd_data = user_ofs;
            A_LIM:   rd_data = {1'b0, pull_lim};
            A_STH:   rd_data = st_hist;
            default: rd_data = '0;
        endcase
    end

    AST_CAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CAL) |=> (cal == $past(wr_data[CAL_W-1:0]))); // R2

    AST_LIM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_LIM) |=> (pull_lim == $past(wr_data[OFS_W-2:0]))); // R11

endmodule

// File: rtl/osl_target.sv
module osl_target
    import osl_pkg::*;
#(
    parameter int OFS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ctl_t                    ctl,
    input  logic signed [CAL_W-1:0] cal,
    input  logic signed [OFS_W-1:0] user_ofs,
    input  logic [OFS_W-2:0]        pull_lim,
    input  logic signed [OFS_W-1:0] ref_ofs,
    input  logic                    ref_lost,
    input  logic signed [OFS_W-1:0] hist_ofs,
    input  logic signed [OFS_W-1:0] st_hist,
    output logic signed [OFS_W-1:0] tgt
);

    localparam int WW = OFS_W + 2;
    localparam logic signed [WW-1:0] SCALE_X = WW'(CAL_SCALE);
    localparam logic signed [WW-1:0] MAX_X   = $signed({3'b000, {(OFS_W-1){1'b1}}});
    localparam logic signed [WW-1:0] MIN_X   = $signed({3'b111, {(OFS_W-1){1'b0}}});

    logic signed [WW-1:0] cal_x;
    logic signed [WW-1:0] base_x;
    logic signed [WW-1:0] lim_x;
    logic signed [WW-1:0] ref_x;
    logic signed [WW-1:0] trk_x;
    logic signed [WW-1:0] sel_x;
    logic signed [WW-1:0] sum_x;

    assign cal_x  = WW'(cal);
    assign base_x = cal_x * SCALE_X;
    assign lim_x  = $signed({3'b000, pull_lim});
    assign ref_x  = WW'(ref_ofs);

    always_comb begin
        trk_x = ref_x;
        if (!ctl.follow) begin
            if (ref_x > lim_x)
                trk_x = lim_x;
            else if (ref_x < -lim_x)
                trk_x = -lim_x;
        end
    end

    always_comb begin
        case (ctl.mode)
            MODE_HOLD: sel_x = ctl.ho_user ? WW'(user_ofs) : WW'(hist_ofs);
            MODE_TRK:  sel_x = ref_lost ? WW'(st_hist) : trk_x;
            default:   sel_x = '0;
        endcase
    end

    assign sum_x = base_x + sel_x;

    always_comb begin
        if (sum_x > MAX_X)
            tgt = MAX_X[OFS_W-1:0];
        else if (sum_x < MIN_X)
            tgt = MIN_X[OFS_W-1:0];
        else
            tgt = sum_x[OFS_W-1:0];
    end

    AST_PULLIN_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_TRK && !ref_lost && !ctl.follow)
            |-> (sel_x <= lim_x && sel_x >= -lim_x)); // R4

    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (sum_x > MAX_X) |-> (tgt == MAX_X[OFS_W-1:0])); // R12

endmodule

// File: rtl/osl_ramp.sv
module osl_ramp
    import osl_pkg::*;
#(
    parameter int OFS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  slew_rate_e              rate,
    input  logic signed [OFS_W-1:0] tgt,
    output logic signed [OFS_W-1:0] ofs_q,
    output logic                    ramping
);

    localparam int DW = OFS_W + 1;

    logic                 half_ph;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] adiff;
    logic signed [DW-1:0] step;
    logic signed [DW-1:0] move;
    logic signed [DW-1:0] nxt;

    assign diff  = DW'(tgt) - DW'(ofs_q);
    assign adiff = (diff < 0) ? -diff : diff;
    assign step  = $signed({{(DW-2){1'b0}}, step_size(rate, half_ph)});
    assign move  = (adiff < step) ? adiff : step;

    always_comb begin
        if (rate == RATE_NONE)
            nxt = DW'(tgt);
        else if (diff > 0)
            nxt = DW'(ofs_q) + move;
        else
            nxt = DW'(ofs_q) - move;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q   <= '0;
            half_ph <= 1'b0;
        end else if (tick) begin
            ofs_q   <= nxt[OFS_W-1:0];
            half_ph <= (rate == RATE_1P5 && diff != 0) ? ~half_ph : 1'b0;
        end
    end

    assign ramping = (diff != 0);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (ofs_q == $past(ofs_q))); // R6

    AST_SNAP: assert property (@(posedge clk) disable iff (rst)
        (tick && rate == RATE_NONE) |=> (ofs_q == $past(tgt))); // R8

    AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (rst)
        (tick && diff > 0) |=> (ofs_q <= $past(tgt) && ofs_q > $past(ofs_q))); // R9

    AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (rst)
        (tick && diff < 0) |=> (ofs_q >= $past(tgt) && ofs_q < $past(ofs_q))); // R9

    AST_HALF_ALT: assert property (@(posedge clk) disable iff (rst)
        (tick && rate != RATE_1P5) |=> !half_ph); // R7

endmodule

// File: rtl/offset_slew_limiter.sv
module offset_slew_limiter
    import osl_pkg::*;
#(
    parameter int OFS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    cfg_wr,
    input  logic [2:0]              cfg_waddr,
    input  logic [OFS_W-1:0]        cfg_wdata,
    input  logic [2:0]              cfg_raddr,
    output logic [OFS_W-1:0]        cfg_rdata,
    input  logic signed [OFS_W-1:0] ref_ofs,
    input  logic                    ref_lost,
    input  logic signed [OFS_W-1:0] hist_ofs,
    input  logic signed [OFS_W-1:0] st_hist,
    output logic signed [OFS_W-1:0] ofs_out,
    output logic                    ramping
);

    ctl_t                    ctl;
    logic signed [CAL_W-1:0] cal;
    logic signed [OFS_W-1:0] user_ofs;
    logic [OFS_W-2:0]        pull_lim;
    logic signed [OFS_W-1:0] tgt;

    osl_regs #(.OFS_W(OFS_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_addr  (cfg_waddr),
        .wr_data  (cfg_wdata),
        .rd_addr  (cfg_raddr),
        .st_hist  (st_hist),
        .rd_data  (cfg_rdata),
        .ctl      (ctl),
        .cal      (cal),
        .user_ofs (user_ofs),
        .pull_lim (pull_lim)
    );

    osl_target #(.OFS_W(OFS_W)) u_target (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cal      (cal),
        .user_ofs (user_ofs),
        .pull_lim (pull_lim),
        .ref_ofs  (ref_ofs),
        .ref_lost (ref_lost),
        .hist_ofs (hist_ofs),
        .st_hist  (st_hist),
        .tgt      (tgt)
    );

    osl_ramp #(.OFS_W(OFS_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rate    (ctl.rate),
        .tgt     (tgt),
        .ofs_q   (ofs_out),
        .ramping (ramping)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (ofs_out == '0)); // R1

endmodule

// File: tb/sim_offset_slew_limiter.sv
module sim_offset_slew_limiter;

    localparam int W    = 24;
    localparam int MAXV = 8388607;
    localparam int MINV = -8388608;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                tick = 1'b0;
    logic                cfg_wr = 1'b0;
    logic [2:0]          cfg_waddr = '0;
    logic [W-1:0]        cfg_wdata = '0;
    logic [2:0]          cfg_raddr = '0;
    logic [W-1:0]        cfg_rdata;
    logic signed [W-1:0] ref_ofs = '0;
    logic                ref_lost = 1'b0;
    logic signed [W-1:0] hist_ofs = '0;
    logic signed [W-1:0] st_hist = '0;
    logic signed [W-1:0] ofs_out;
    logic                ramping;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_div = 0;
    int tick_cnt = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_ctl = 0, m_cal = 0, m_user = 0, m_lim = 0;
    int m_out = 0;
    bit m_ph = 0;

    offset_slew_limiter #(.OFS_W(W)) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .ref_ofs(ref_ofs), .ref_lost(ref_lost), .hist_ofs(hist_ofs),
        .st_hist(st_hist), .ofs_out(ofs_out), .ramping(ramping)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    function automatic int f_tgt();
        int sel;
        int sum;
        int r;
        sel = 0;
        case (m_ctl & 3)
            1: sel = ((m_ctl >> 2) & 1) ? m_user : int'(hist_ofs);
            2: begin
                if (ref_lost) sel = int'(st_hist);
                else begin
                    r = int'(ref_ofs);
                    if (((m_ctl >> 3) & 1) == 0) begin
                        if (r > m_lim) r = m_lim;
                        else if (r < -m_lim) r = -m_lim;
                    end
                    sel = r;
                end
            end
            default: sel = 0;
        endcase
        sum = m_cal * 100 + sel;
        if (sum > MAXV) sum = MAXV;
        if (sum < MINV) sum = MINV;
        return sum;
    endfunction

    function automatic int f_rd();
        case (cfg_raddr)
            3'd0: return m_ctl;
            3'd1: return m_cal;
            3'd2: return m_user;
            3'd3: return m_lim;
            3'd4: return int'(st_hist);
            default: return 0;
        endcase
    endfunction

    // reference model, updated on every rising edge and compared 2 ns later
    always @(posedge clk) begin
        int t, rate, stp, d, ad, mv, v;
        cycles++;
        if (rst) begin
            m_ctl = 0; m_cal = 0; m_user = 0; m_lim = 0; m_out = 0; m_ph = 0;
        end else begin
            if (tick) begin
                t = f_tgt();
                rate = (m_ctl >> 4) & 3;
                if (rate == 3) begin
                    m_out = t; m_ph = 0;
                end else begin
                    stp = (rate == 0) ? 1 : (rate == 2) ? 2 : (m_ph ? 2 : 1);
                    d = t - m_out;
                    if (d == 0) m_ph = 0;
                    else begin
                        m_ph = (rate == 1) ? !m_ph : 1'b0;
                        ad = (d < 0) ? -d : d;
                        mv = (ad < stp) ? ad : stp;
                        m_out = (d > 0) ? m_out + mv : m_out - mv;
                    end
                end
            end
            if (cfg_wr) begin
                v = int'($signed(cfg_wdata));
                case (cfg_waddr)
                    3'd0: m_ctl = int'(cfg_wdata[5:0]);
                    3'd1: begin m_cal = int'(cfg_wdata[10:0]); if (m_cal >= 1024) m_cal -= 2048; end
                    3'd2: m_user = v;
                    3'd3: m_lim = int'(cfg_wdata[W-2:0]);
                    default: ;
                endcase
            end
        end
        #2;
        if (!done) begin
            chk(cur_req, "ofs_out", int'(ofs_out), m_out);
            chk("R10", "ramping", int'(ramping), int'(m_out != f_tgt()));
            chk("R11", "cfg_rdata", int'($signed(cfg_rdata)), f_rd());
        end
    end

    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick <= 1'b0; tick_cnt <= 0;
        end else begin
            tick <= (tick_cnt == tick_div - 1);
            tick_cnt <= (tick_cnt >= tick_div - 1) ? 0 : tick_cnt + 1;
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_waddr = a; cfg_wdata = W'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ctl(input int mode, input int ho_user, input int follow, input int rate);
        wr(3'd0, mode | (ho_user << 2) | (follow << 3) | (rate << 4));
    endtask

    task automatic settle();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!ramping && i > 4) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        int prev;
        int steps[$];
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", "ofs_out in reset", int'(ofs_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ofs_out after reset", int'(ofs_out), 0);
        chk("R1", "ramping after reset", int'(ramping), 0);
        tick_div = 2;

        // freerun snap
        cur_req = "R8";
        ctl(0, 0, 0, 3);
        wr(3'd1, 5);
        settle();
        chk("R2", "freerun +0.5ppm", int'(ofs_out), 500);

        // freerun ramp down at rate 1
        cur_req = "R6";
        ctl(0, 0, 0, 0);
        wr(3'd1, -3);
        repeat (40) @(negedge clk);
        chk("R6", "rate 1 partial ramp", int'(ofs_out) < 500 && int'(ofs_out) > 470 ? 1 : 0, 1);
        settle();
        chk("R2", "freerun -0.3ppm", int'(ofs_out), -300);

        // tick stopped: target change has no effect
        cur_req = "R6";
        tick_div = 0;
        ctl(3, 0, 0, 3);
        wr(3'd1, 12);
        repeat (20) @(negedge clk);
        chk("R6", "no tick holds output", int'(ofs_out), -300);
        chk("R10", "ramping while held", int'(ramping), 1);
        tick_div = 2;
        settle();
        chk("R2", "mode 3 acts as freerun", int'(ofs_out), 1200);

        // holdover with accumulated history, rate 2, odd distance
        cur_req = "R9";
        hist_ofs = 1001;
        ctl(1, 0, 0, 2);
        settle();
        chk("R3", "holdover history", int'(ofs_out), 2201);

        // holdover user value, rate 1.5
        cur_req = "R7";
        wr(3'd2, -57);
        ctl(1, 1, 0, 1);
        prev = int'(ofs_out);
        for (int i = 0; i < 12; i++) begin
            @(posedge tick);
            @(negedge clk);
            steps.push_back(prev - int'(ofs_out));
            prev = int'(ofs_out);
        end
        for (int i = 0; i < 12; i++)
            chk("R7", "1.5 step size", steps[i], (i % 2 == 0) ? 1 : 2);
        ctl(1, 1, 0, 0);
        ctl(1, 1, 0, 1);
        settle();
        chk("R3", "holdover user", int'(ofs_out), 1143);

        // tracking, clamped and followed
        cur_req = "R4";
        wr(3'd1, 0);
        wr(3'd3, 1500);
        ref_ofs = 2000;
        ctl(2, 0, 0, 3);
        settle();
        chk("R4", "clamp high", int'(ofs_out), 1500);
        ref_ofs = -2500;
        settle();
        chk("R4", "clamp low", int'(ofs_out), -1500);
        ctl(2, 0, 1, 2);
        settle();
        chk("R4", "follow beyond limit", int'(ofs_out), -2500);

        // reference lost
        cur_req = "R5";
        st_hist = 333;
        ref_lost = 1'b1;
        settle();
        chk("R5", "short-term history", int'(ofs_out), 333);
        ref_lost = 1'b0;

        // saturation
        cur_req = "R12";
        ctl(2, 0, 1, 3);
        wr(3'd3, MAXV);
        wr(3'd1, 1023);
        ref_ofs = 8300000;
        settle();
        chk("R12", "saturate high", int'(ofs_out), MAXV);
        wr(3'd1, -1024);
        ref_ofs = -8300000;
        settle();
        chk("R12", "saturate low", int'(ofs_out), MINV);

        // readback sweep
        cur_req = "R11";
        st_hist = -4242;
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            cfg_raddr = 3'(a);
        end
        @(negedge clk);
        cfg_raddr = 3'd1;
        @(negedge clk);
        chk("R11", "cal readback sign-extended", int'($signed(cfg_rdata)), -1024);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule